// File: doc/BRIEF.md
# DMA Channel Transfer-Mode Sequencer

This block sequences a single DMA channel. Software programs it by writing a configuration word: an enable bit, an interrupt-enable bit, a 3-bit transfer mode and a preload count. Once enabled, the sequencer issues one single-cycle transfer strobe for each data word to be moved. It waits for a per-word completion pulse from the data path before it issues the next strobe or goes back to waiting. Address generation, bus arbitration and the data path itself sit outside the block.

The mode field picks what starts the transfer and how much moves per trigger. A request can start a whole block, a single word, or a line of `LINE_LEN` words. In one mode the enable bit alone starts a block. The mode also decides whether the enable bit clears itself when the block ends and whether an end-of-block interrupt is raised. Each time a block finishes, the live count returns to the preload value. The interrupt request is sticky: only the acknowledge input clears it. Software clearing the enable bit part-way through a block also raises it.

Top module: `dma_mode_seq`

## Requirements
- R1: After reset, `xfer_o`, `busy_o`, `en_o` and `irq_o` are 0 and `cnt_o` is 0.
- R2: In modes 3'b000 and 3'b100, one `req_i` pulse moves the whole block. The first strobe comes on the cycle after the request is sampled, and each further strobe comes on the cycle after an accepted `done_i`. `cnt_o` reads the remaining word count at every strobe.
- R3: In mode 3'b011, an enabled channel with a nonzero count starts a block without any request.
- R4: In modes 3'b001 and 3'b101, each request moves exactly one word. A request that arrives while a word is in flight is held (one deep) and served after that word completes.
- R5: In mode 3'b010, each request moves `LINE_LEN` words, or fewer if fewer remain in the block.
- R6: When the last word of a block completes, `cnt_o` returns to the preload value. In modes 3'b000 to 3'b011, `en_o` drops to 0 on the same edge.
- R7: In modes 3'b100 and 3'b101, `en_o` stays 1 at the end of a block, no end-of-block interrupt is raised, and the next request starts a new block.
- R8: In modes 3'b000 to 3'b011 with interrupt enable set, `irq_o` rises at the end of a block. It then stays 1 until an `irq_ack_i` pulse.
- R9: A configuration write with the enable bit 0 while a block is partly done stops the channel. If interrupt enable was set, it also sets `irq_o`. The same write made while no block is in progress raises no interrupt.
- R10: Modes 3'b110 and 3'b111 never produce a strobe or an interrupt.
- R11: `xfer_o` is high for one cycle only. `done_i` is accepted only while `busy_o` is 1 and `xfer_o` is 0.
- R12: An enabled channel whose preload count is 0 issues no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe; loads all cfg_* fields and the count |
| cfg_en | input | 1 | Channel enable value written |
| cfg_ie | input | 1 | Interrupt enable value written |
| cfg_mode | input | 3 | Transfer mode value written |
| cfg_cnt | input | CW | Preload word count written |
| req_i | input | 1 | Peripheral request pulse |
| done_i | input | 1 | Per-word completion pulse from the data path |
| irq_ack_i | input | 1 | Interrupt service acknowledge; clears the sticky request |
| xfer_o | output | 1 | One-cycle word transfer strobe |
| busy_o | output | 1 | A word or a burst of words is in flight |
| en_o | output | 1 | Current channel enable state |
| irq_o | output | 1 | Sticky interrupt request |
| cnt_o | output | CW | Live remaining word count |

## Verification
The bench aims at the behaviour at block ends. There it checks that the count reloads and that the enable clears in the self-clearing modes but not in the repeating ones. A design that decoded the wrong bit would either leave a finished channel armed or stop a repeating one. The bench also sends a second request while a word is still in flight in a word mode, which would be lost if the pending flag were missing. It runs a line-mode block whose length is not a multiple of the line, which overruns or stalls if the line counter and the block counter disagree. It also disables the channel both mid-block and between blocks, which catches a design that raises the abort interrupt in the wrong case or not at all.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    UNIT_BLOCK = 2'd0,
    UNIT_WORD  = 2'd1,
    UNIT_LINE  = 2'd2
  } unit_e;

  typedef struct packed {
    logic  valid;     // encoding defined
    logic  trig_req;  // started by a peripheral request
    logic  trig_en;   // started by the enable bit alone
    unit_e unit;      // amount moved per trigger
    logic  auto_clr;  // enable drops at block end
    logic  eob_irq;   // end-of-block interrupt allowed
  } mode_attr_t;

endpackage

// File: rtl/dma_mode_dec.sv
module dma_mode_dec
  import dma_seq_pkg::*;
(
  input  logic [2:0]  mode,
  output mode_attr_t  attr
);
  always_comb begin
    attr = '{valid: 1'b0, trig_req: 1'b0, trig_en: 1'b0, unit: UNIT_BLOCK,
             auto_clr: 1'b0, eob_irq: 1'b0};
    case (mode)
      3'b000: attr = '{1'b1, 1'b1, 1'b0, UNIT_BLOCK, 1'b1, 1'b1};
      3'b001: attr = '{1'b1, 1'b1, 1'b0, UNIT_WORD,  1'b1, 1'b1};
      3'b010: attr = '{1'b1, 1'b1, 1'b0, UNIT_LINE,  1'b1, 1'b1};
      3'b011: attr = '{1'b1, 1'b0, 1'b1, UNIT_BLOCK, 1'b1, 1'b1};
      3'b100: attr = '{1'b1, 1'b1, 1'b0, UNIT_BLOCK, 1'b0, 1'b0};
      3'b101: attr = '{1'b1, 1'b1, 1'b0, UNIT_WORD,  1'b0, 1'b0};
      default: ;
    endcase
  end
endmodule

// File: rtl/dma_dcnt.sv
// Down counter that remembers its load value and can return to it.
module dma_dcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         dec,
  input  logic         reload,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  logic [W-1:0] orig_q, cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      orig_q <= '0;
      cnt_q  <= '0;
    end else if (ld) begin
      orig_q <= ld_val;
      cnt_q  <= ld_val;
    end else if (reload) begin
      cnt_q  <= orig_q;
    end else if (dec) begin
      cnt_q  <= cnt_q - W'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == W'(1));
endmodule

// File: rtl/dma_mode_seq.sv
module dma_mode_seq
  import dma_seq_pkg::*;
#(
  parameter int CW       = 16,
  parameter int LINE_LEN = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_en,
  input  logic          cfg_ie,
  input  logic [2:0]    cfg_mode,
  input  logic [CW-1:0] cfg_cnt,
  input  logic          req_i,
  input  logic          done_i,
  input  logic          irq_ack_i,
  output logic          xfer_o,
  output logic          busy_o,
  output logic          en_o,
  output logic          irq_o,
  output logic [CW-1:0] cnt_o
);
  localparam int LW = $clog2(LINE_LEN + 1);

  logic       en_q, ie_q, busy_q, xfer_q, pend_q, in_blk_q, irq_q;
  logic [2:0] mode_q;
  mode_attr_t attr;

  logic [CW-1:0] blk_cnt;
  logic [LW-1:0] line_cnt;
  logic          blk_last, line_last;
  logic          start, acc, fin, cont, abort, word_unit;

  dma_mode_dec u_dec (.mode(mode_q), .attr(attr));

  assign word_unit = (attr.unit == UNIT_WORD);

  // Trigger: enable-only mode, or a live or held request.
  assign start = !cfg_we && en_q && !busy_q && attr.valid && (blk_cnt != '0) &&
                 (attr.trig_en || (attr.trig_req && (req_i || pend_q)));
  assign acc   = !cfg_we && busy_q && !xfer_q && done_i;
  assign fin   = acc && blk_last;
  assign cont  = acc && !blk_last &&
                 ((attr.unit == UNIT_BLOCK) || ((attr.unit == UNIT_LINE) && !line_last));
  assign abort = cfg_we && !cfg_en && (busy_q || in_blk_q);

  dma_dcnt #(.W(CW)) u_blk (
    .clk(clk), .rst(rst),
    .ld(cfg_we), .ld_val(cfg_cnt),
    .dec(acc && !blk_last), .reload(fin),
    .cnt_o(blk_cnt), .last_o(blk_last)
  );

  dma_dcnt #(.W(LW)) u_line (
    .clk(clk), .rst(rst),
    .ld(start), .ld_val(LW'(LINE_LEN)),
    .dec(acc && (attr.unit == UNIT_LINE)), .reload(1'b0),
    .cnt_o(line_cnt), .last_o(line_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      ie_q     <= 1'b0;
      mode_q   <= 3'b000;
      busy_q   <= 1'b0;
      xfer_q   <= 1'b0;
      pend_q   <= 1'b0;
      in_blk_q <= 1'b0;
      irq_q    <= 1'b0;
    end else if (cfg_we) begin
      en_q     <= cfg_en;
      ie_q     <= cfg_ie;
      mode_q   <= cfg_mode;
      busy_q   <= 1'b0;
      xfer_q   <= 1'b0;
      pend_q   <= 1'b0;
      in_blk_q <= 1'b0;
      if (abort && ie_q)  irq_q <= 1'b1;
      else if (irq_ack_i) irq_q <= 1'b0;
    end else begin
      xfer_q <= start || cont;

      if (start)                busy_q <= 1'b1;
      else if (acc && !cont)    busy_q <= 1'b0;

      if (start)                in_blk_q <= 1'b1;
      else if (fin)             in_blk_q <= 1'b0;

      // Held request: word modes only, one deep.
      if (fin && attr.auto_clr)
        pend_q <= 1'b0;
      else if (word_unit && en_q && req_i && (busy_q || (start && pend_q)))
        pend_q <= 1'b1;
      else if (start)
        pend_q <= 1'b0;

      if (fin && attr.auto_clr) en_q <= 1'b0;

      if (fin && ie_q && attr.eob_irq) irq_q <= 1'b1;
      else if (irq_ack_i)              irq_q <= 1'b0;
    end
  end

  assign xfer_o = xfer_q;
  assign busy_o = busy_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;
  assign cnt_o  = blk_cnt;
endmodule

// File: rtl/dma_mode_seq_chk.sv
module dma_mode_seq_chk #(
  parameter int CW = 16,
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_we,
  input logic          done_i,
  input logic          irq_ack_i,
  input logic          xfer_o,
  input logic          busy_o,
  input logic          en_o,
  input logic          irq_o,
  input logic [CW-1:0] cnt_o,
  input logic [2:0]    mode_q,
  input logic [LW-1:0] line_cnt
);
  a_r11_single_strobe: assert property (@(posedge clk) disable iff (rst)
    xfer_o |=> !xfer_o);

  a_r11_strobe_busy: assert property (@(posedge clk) disable iff (rst)
    xfer_o |-> busy_o);

  a_r10_reserved_idle: assert property (@(posedge clk) disable iff (rst)
    (mode_q[2:1] == 2'b11) |-> (!xfer_o && !busy_o));

  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !irq_ack_i) |=> irq_o);

  a_r7_no_eob_irq: assert property (@(posedge clk) disable iff (rst)
    (!irq_o && !cfg_we && mode_q[2]) |=> !irq_o);

  a_r6_autoclear: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !xfer_o && done_i && !cfg_we && cnt_o == CW'(1) && !mode_q[2])
      |=> !en_o);

  a_r12_zero_count: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == '0) |-> !xfer_o);

  a_r5_line_bound: assert property (@(posedge clk) disable iff (rst)
    (busy_o && mode_q == 3'b010) |-> (line_cnt != '0));
endmodule

bind dma_mode_seq dma_mode_seq_chk #(.CW(CW), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .done_i(done_i),
  .irq_ack_i(irq_ack_i), .xfer_o(xfer_o), .busy_o(busy_o), .en_o(en_o),
  .irq_o(irq_o), .cnt_o(cnt_o), .mode_q(mode_q), .line_cnt(line_cnt)
);

// File: tb/dma_mode_seq_tb.sv
`timescale 1ns/1ps
module dma_mode_seq_tb;
  localparam int CW = 8;
  localparam int LINE = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0, cfg_en = 0, cfg_ie = 0;
  logic [2:0] cfg_mode = 0;
  logic [CW-1:0] cfg_cnt = 0;
  logic req_i = 0, done_i = 0, irq_ack_i = 0;
  logic xfer_o, busy_o, en_o, irq_o;
  logic [CW-1:0] cnt_o;

  int nchk = 0, nfail = 0;
  int expq[$];
  logic auto_done = 1'b1, want = 1'b0;

  always #10 clk = ~clk;

  dma_mode_seq #(.CW(CW), .LINE_LEN(LINE)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_ie(cfg_ie),
    .cfg_mode(cfg_mode), .cfg_cnt(cfg_cnt), .req_i(req_i), .done_i(done_i),
    .irq_ack_i(irq_ack_i), .xfer_o(xfer_o), .busy_o(busy_o), .en_o(en_o),
    .irq_o(irq_o), .cnt_o(cnt_o)
  );

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Data-path model: completion pulse two cycles after each strobe.
  always @(negedge clk) begin
    done_i = want;
    want   = xfer_o && auto_done;
  end

  // Monitor: each strobe pops the remaining count it should carry.
  always @(negedge clk) begin
    if (!rst && xfer_o) begin
      if (expq.size() == 0) chk("R2/R10 unexpected strobe, cnt", cnt_o, -1);
      else                  chk("R2 strobe count", cnt_o, expq.pop_front());
    end
  end

  task automatic cfg(input logic en, input logic ie, input logic [2:0] m,
                     input int n);
    @(negedge clk);
    cfg_en = en; cfg_ie = ie; cfg_mode = m; cfg_cnt = CW'(n); cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse_req();
    @(negedge clk); req_i = 1;
    @(negedge clk); req_i = 0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack_i = 1;
    @(negedge clk); irq_ack_i = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    idle(3);
    rst = 0;
    idle(1);
    // R1 reset state
    chk("R1 xfer", xfer_o, 0); chk("R1 busy", busy_o, 0);
    chk("R1 en", en_o, 0); chk("R1 irq", irq_o, 0); chk("R1 cnt", cnt_o, 0);

    // R2/R6/R8: request-started block, mode 000
    cfg(1, 1, 3'b000, 3);
    idle(6);                                   // no strobe without request
    expq.push_back(3); expq.push_back(2); expq.push_back(1);
    pulse_req();
    idle(12);
    chk("R6 en cleared", en_o, 0);
    chk("R6 count reloaded", cnt_o, 3);
    chk("R8 irq raised", irq_o, 1);
    idle(8);
    chk("R8 irq sticky", irq_o, 1);
    ack();
    chk("R8 irq acked", irq_o, 0);

    // R3: enable-started block, no interrupt enable
    expq.push_back(2); expq.push_back(1);
    cfg(1, 0, 3'b011, 2);
    idle(10);
    chk("R3 en cleared", en_o, 0);
    chk("R3 no irq", irq_o, 0);
    chk("R3 count reloaded", cnt_o, 2);

    // R4: word mode 001, second request while busy is held
    cfg(1, 1, 3'b001, 3);
    expq.push_back(3);
    pulse_req();
    idle(6);
    chk("R4 one word only, cnt", cnt_o, 2);
    chk("R4 still enabled", en_o, 1);
    chk("R4 idle between words", busy_o, 0);
    expq.push_back(2); expq.push_back(1);
    @(negedge clk); req_i = 1;
    @(negedge clk); req_i = 1;                 // arrives while busy
    @(negedge clk); req_i = 0;
    idle(10);
    chk("R4 held request served, en", en_o, 0);
    chk("R4 block end irq", irq_o, 1);
    chk("R4 count reloaded", cnt_o, 3);
    ack();

    // R5: line mode, 5 words in lines of 2
    cfg(1, 0, 3'b010, 5);
    expq.push_back(5); expq.push_back(4);
    pulse_req(); idle(8);
    chk("R5 first line, cnt", cnt_o, 3);
    chk("R5 first line, busy", busy_o, 0);
    expq.push_back(3); expq.push_back(2);
    pulse_req(); idle(8);
    chk("R5 second line, cnt", cnt_o, 1);
    expq.push_back(1);
    pulse_req(); idle(8);
    chk("R5 short last line, en", en_o, 0);
    chk("R5 count reloaded", cnt_o, 5);

    // R7: repeating block mode 100
    cfg(1, 1, 3'b100, 2);
    expq.push_back(2); expq.push_back(1);
    pulse_req(); idle(8);
    chk("R7 en kept", en_o, 1);
    chk("R7 no eob irq", irq_o, 0);
    chk("R7 count reloaded", cnt_o, 2);
    expq.push_back(2); expq.push_back(1);
    pulse_req(); idle(8);
    chk("R7 second block, irq", irq_o, 0);
    // R9 negative: disable between blocks
    cfg(0, 1, 3'b100, 2);
    idle(2);
    chk("R9 disable when idle, no irq", irq_o, 0);

    // R7/R4: repeating word mode 101, two quick requests
    cfg(1, 1, 3'b101, 2);
    expq.push_back(2); expq.push_back(1);
    @(negedge clk); req_i = 1;
    @(negedge clk); req_i = 1;
    @(negedge clk); req_i = 0;
    idle(10);
    chk("R7 word mode en kept", en_o, 1);
    chk("R7 word mode no irq", irq_o, 0);
    expq.push_back(2);
    pulse_req(); idle(6);
    chk("R7 new block started, cnt", cnt_o, 1);
    // R9: disable mid-block between words
    cfg(0, 1, 3'b101, 2);
    idle(2);
    chk("R9 abort between words irq", irq_o, 1);
    chk("R9 abort en", en_o, 0);
    ack();

    // R9: disable with a word in flight
    auto_done = 0;
    cfg(1, 1, 3'b000, 4);
    expq.push_back(4);
    pulse_req(); idle(4);
    chk("R11 waits for done", busy_o, 1);
    cfg(0, 1, 3'b000, 4);
    idle(2);
    chk("R9 abort busy", busy_o, 0);
    chk("R9 abort irq", irq_o, 1);
    auto_done = 1;
    ack();

    // R10: reserved mode
    cfg(1, 1, 3'b110, 3);
    pulse_req(); idle(10);
    chk("R10 reserved busy", busy_o, 0);
    chk("R10 reserved irq", irq_o, 0);
    cfg(1, 1, 3'b111, 3);
    pulse_req(); idle(10);
    chk("R10 reserved 111 irq", irq_o, 0);

    // R12: zero count
    cfg(1, 1, 3'b011, 0);
    idle(10);
    chk("R12 zero count busy", busy_o, 0);
    chk("R12 zero count irq", irq_o, 0);

    chk("R2 all expected strobes seen", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule